// File: doc/BRIEF.md
# Paired Address Compare Debug Unit

This unit watches the instruction fetch stream and raises debug events when a fetch address matches a pair of programmable compare registers, A and B. A two-bit mode selects how the pair is used: two independent exact comparators, a value and mask pair, an inclusive address window, or the region outside such a window.

Each event is also gated by a privilege qualifier and a translation-space qualifier. These are checked against the current user-mode bit and address-space bit that come with each fetch. Software loads the two compare registers and the control word through a small write port.

The event flags are registered. Each one appears as a single-cycle pulse in the cycle after the fetch that caused it.

Top module: `addr_cmp_pair`

## Requirements
- R1: After reset, compare registers A and B and every control field are zero, and evt_a and evt_b are low.
- R2: A write with wr_sel=0 loads register A and wr_sel=1 loads register B. A write with wr_sel=2 loads the control word from wr_data as follows: mode [1:0], privilege A [3:2], space A [5:4], privilege B [7:6], space B [9:8]. A write with wr_sel=3 changes nothing. A write takes effect for fetches in the following cycle.
- R3: In mode 0, evt_a fires when the address equals A. Independently, evt_b fires when the address equals B, using B's own qualifiers.
- R4: In mode 1, evt_a fires when (address & B) equals (A & B).
- R5: In mode 2, evt_a fires when A <= address < B, compared as unsigned numbers.
- R6: In mode 3, evt_a fires when address < A or address >= B, compared as unsigned numbers.
- R7: In modes 1, 2 and 3, evt_b never fires, and only A's qualifiers gate evt_a.
- R8: Privilege code 0 ignores user_mode. Code 2 allows a match only when user_mode=0. Code 3 allows a match only when user_mode=1.
- R9: Privilege code 1 never allows a match.
- R10: Space code 0 ignores addr_space. Code 2 allows a match only when addr_space=0. Code 3 allows a match only when addr_space=1.
- R11: Space code 1 never allows a match.
- R12: An event is a single-cycle pulse in the cycle after a fetch with fetch_valid high. No event follows a cycle with fetch_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 A, 1 B, 2 control, 3 none |
| wr_data | input | ADDR_W | Write data |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| user_mode | input | 1 | 1 = user state, 0 = supervisor state |
| addr_space | input | 1 | Instruction address-space bit |
| evt_a | output | 1 | Event A pulse |
| evt_b | output | 1 | Event B pulse |

## Verification
The bench builds the unit with ADDR_W left at 32, so the range modes can be tested across the full unsigned span. This includes bounds that straddle 0x8000_0000, where a signed compare would give the wrong answer, and addresses at 0xFFFF_FFFF. A behavioural model predicts both event outputs on every clock. It is checked against directed cases at each window edge and each qualifier code, and then against a sweep of random control words and addresses drawn close to the programmed bounds.

// File: rtl/addr_cmp_pair.sv
module addr_cmp_pair #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              user_mode,
  input  logic              addr_space,
  output logic              evt_a,
  output logic              evt_b
);
  logic [ADDR_W-1:0] reg_a, reg_b;
  logic [1:0] mode, priv_a, space_a, priv_b, space_b;
  logic qual_a, qual_b, hit_a, hit_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a   <= '0;
      reg_b   <= '0;
      mode    <= '0;
      priv_a  <= '0;
      space_a <= '0;
      priv_b  <= '0;
      space_b <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: reg_a <= wr_data;
        2'd1: reg_b <= wr_data;
        2'd2: {space_b, priv_b, space_a, priv_a, mode} <= wr_data[9:0];
        default: ;
      endcase
    end
  end

  function automatic logic qual_ok(input logic [1:0] pq, input logic [1:0] sq,
                                   input logic um, input logic as);
    logic p_ok, s_ok;
    p_ok = (pq == 2'b00) || (pq[1] && (pq[0] == um));
    s_ok = (sq == 2'b00) || (sq[1] && (sq[0] == as));
    return p_ok && s_ok;
  endfunction

  assign qual_a = qual_ok(priv_a, space_a, user_mode, addr_space);
  assign qual_b = qual_ok(priv_b, space_b, user_mode, addr_space);

  always_comb begin
    hit_b = 1'b0;
    case (mode)
      2'b00: begin
        hit_a = (fetch_addr == reg_a);
        hit_b = (fetch_addr == reg_b);
      end
      2'b01:   hit_a = ((fetch_addr & reg_b) == (reg_a & reg_b));
      2'b10:   hit_a = (fetch_addr >= reg_a) && (fetch_addr < reg_b);
      default: hit_a = (fetch_addr < reg_a) || (fetch_addr >= reg_b);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_a <= 1'b0;
      evt_b <= 1'b0;
    end else begin
      evt_a <= fetch_valid && hit_a && qual_a;
      evt_b <= fetch_valid && hit_b && qual_b;
    end
  end
endmodule

// File: rtl/addr_cmp_pair_chk.sv
module addr_cmp_pair_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] reg_a,
  input logic [ADDR_W-1:0] reg_b,
  input logic [1:0]        mode,
  input logic [1:0]        priv_a,
  input logic [1:0]        space_a,
  input logic [1:0]        priv_b,
  input logic [1:0]        space_b,
  input logic              evt_a,
  input logic              evt_b
);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (!evt_a && !evt_b));

  assert_b_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |=> !evt_b);

  assert_priv_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_a == 2'b01) |=> !evt_a);

  assert_space_rsvd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (space_a == 2'b01 || (mode == 2'b00 && space_b == 2'b01 && priv_b == 2'b00)) |=>
      (space_a == 2'b01 ? !evt_a : !evt_b));

  assert_exact_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && mode == 2'b00 && fetch_addr == reg_a &&
     priv_a == 2'b00 && space_a == 2'b00) |=> evt_a);

  assert_window_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && fetch_addr < reg_a) |=> !evt_a);
endmodule

bind addr_cmp_pair addr_cmp_pair_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_addr_cmp_pair.sv
module test_addr_cmp_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        user_mode = 1'b0;
  logic        addr_space = 1'b0;
  logic        evt_a, evt_b;

  int n_tests = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";

  // reference state
  logic [31:0] m_a = 0, m_b = 0;
  logic [9:0]  m_ctl = 0;
  logic        exp_a = 0, exp_b = 0;

  addr_cmp_pair #(.ADDR_W(32)) i_addr_cmp_pair (.*);

  always #4 clk = ~clk;

  function automatic bit allow(input logic [1:0] code, input logic bitv);
    if (code == 2'b00) return 1;
    if (code == 2'b01) return 0;
    if (code == 2'b10) return bitv == 1'b0;
    return bitv == 1'b1;
  endfunction

  always @(posedge clk) begin
    bit a, b;
    logic [1:0] md;
    md = m_ctl[1:0];
    a = 0; b = 0;
    if (!rst_n) begin
      m_a <= 0; m_b <= 0; m_ctl <= 0; exp_a <= 0; exp_b <= 0;
    end else begin
      if (fetch_valid) begin
        if (md == 0) begin
          a = (fetch_addr == m_a);
          b = (fetch_addr == m_b) && allow(m_ctl[7:6], user_mode) && allow(m_ctl[9:8], addr_space);
        end else if (md == 1) a = ((fetch_addr ^ m_a) & m_b) == 0;
        else if (md == 2) a = (fetch_addr >= m_a) && (fetch_addr < m_b);
        else a = !((fetch_addr >= m_a) && (fetch_addr < m_b));
        a = a && allow(m_ctl[3:2], user_mode) && allow(m_ctl[5:4], addr_space);
      end
      exp_a <= a; exp_b <= b;
      if (wr_en && wr_sel == 0) m_a <= wr_data;
      if (wr_en && wr_sel == 1) m_b <= wr_data;
      if (wr_en && wr_sel == 2) m_ctl <= wr_data[9:0];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_tests++;
      if (evt_a !== exp_a || evt_b !== exp_b) begin
        n_fail++;
        $display("FAIL %s: evt_a/evt_b actual %b%b expected %b%b (cycle %0d)",
                 cur_req, evt_a, evt_b, exp_a, exp_b, cycles);
      end
    end
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; fetch_valid = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [31:0] ctl(input int md, input int pa, input int sa,
                                      input int pb, input int sb);
    return {22'd0, 2'(sb), 2'(pb), 2'(sa), 2'(pa), 2'(md)};
  endfunction

  task automatic fetch(input logic [31:0] ad, input logic um, input logic as,
                       input logic v = 1);
    fetch_valid = v; fetch_addr = ad; user_mode = um; addr_space = as;
    @(negedge clk);
    fetch_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (evt_a !== 0 || evt_b !== 0) begin
      n_fail++;
      $display("FAIL R1: reset events actual %b%b expected 00", evt_a, evt_b);
    end
    rst_n = 1;
    cur_req = "R1";
    @(negedge clk);
    fetch(32'h0, 0, 0); fetch(32'h0, 1, 1); fetch(32'h4, 0, 0);
    @(negedge clk);

    cur_req = "R3";
    wr(0, 32'h1000); wr(1, 32'h2000);
    fetch(32'h1000, 0, 0); fetch(32'h2000, 1, 0); fetch(32'h1500, 0, 1);
    cur_req = "R2";
    wr(3, 32'h1500);
    fetch(32'h1500, 0, 0); fetch(32'h1000, 0, 0);
    wr(2, ctl(0, 0, 0, 2, 0));
    fetch(32'h2000, 1, 0); fetch(32'h2000, 0, 0);

    cur_req = "R4";
    wr(0, 32'h1234_5600); wr(1, 32'hFFFF_FF00); wr(2, ctl(1, 0, 0, 0, 0));
    fetch(32'h1234_56AB, 0, 0); fetch(32'h1234_57AB, 0, 0); fetch(32'hFFFF_FF00, 0, 0);

    cur_req = "R5";
    wr(0, 32'h100); wr(1, 32'h200); wr(2, ctl(2, 0, 0, 0, 0));
    fetch(32'hFF, 0, 0); fetch(32'h100, 0, 0); fetch(32'h1FF, 0, 0); fetch(32'h200, 0, 0);
    wr(0, 32'h7FFF_FFF0); wr(1, 32'hFFFF_FFFF);
    fetch(32'h8000_0000, 0, 0); fetch(32'hFFFF_FFFF, 0, 0); fetch(32'h0, 0, 0);

    cur_req = "R6";
    wr(2, ctl(3, 0, 0, 0, 0));
    fetch(32'h8000_0000, 0, 0); fetch(32'hFFFF_FFFF, 0, 0); fetch(32'h0, 0, 0);
    fetch(32'h7FFF_FFEF, 0, 0); fetch(32'h7FFF_FFF0, 0, 0);

    cur_req = "R7";
    wr(0, 32'h300); wr(1, 32'h300); wr(2, ctl(2, 0, 0, 0, 0));
    wr(1, 32'h400); wr(2, ctl(1, 2, 0, 3, 1));
    fetch(32'h400, 0, 0); fetch(32'h400, 1, 1); fetch(32'h300, 0, 1);

    wr(0, 32'hABC0); wr(1, 32'hABC0);
    for (int pc = 0; pc < 4; pc++) begin
      cur_req = (pc == 1) ? "R9" : "R8";
      wr(2, ctl(0, pc, 0, pc, 0));
      fetch(32'hABC0, 0, 0); fetch(32'hABC0, 1, 0); fetch(32'hABC0, 1, 1);
    end
    for (int sc = 0; sc < 4; sc++) begin
      cur_req = (sc == 1) ? "R11" : "R10";
      wr(2, ctl(0, 0, sc, 0, sc));
      fetch(32'hABC0, 0, 0); fetch(32'hABC0, 0, 1); fetch(32'hABC0, 1, 1);
    end

    cur_req = "R12";
    wr(2, ctl(0, 0, 0, 0, 0));
    fetch(32'hABC0, 0, 0, 0); fetch(32'hABC0, 0, 0); fetch(32'hABC0, 0, 0, 0);
    fetch(32'hABC0, 0, 0); fetch(32'hABC0, 0, 0);

    cur_req = "R3-R12 sweep";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] base;
      base = $urandom;
      if (i % 50 == 0) begin
        wr(0, base); wr(1, base + ($urandom % 64)); wr(2, $urandom);
      end
      fetch(base + ($urandom % 96) - 16, 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0));
      if (i % 50 == 49) wr(0, $urandom % 8 == 0 ? 32'hFFFF_FFFF : 32'h0);
    end

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule